// File: doc/BRIEF.md
# Video Scanline Fetch Sequencer

This block keeps the dot and scanline position of a tile-based video processor and derives from it everything that follows a fixed per-line timetable. That covers the memory request strobe and its fetch type, the two scroll-copy strobes, the horizontal blank, the active-picture flag, and a flag that says when control-register writes may be accepted. The pixel shifters, sprite evaluation, palette lookup and analog output sit outside and consume these signals. The memory data path is represented only by the request and type outputs.

A line is 341 dots long (0 to 340) and a frame is 262 lines (0 to 261). Line 261 is the pre-render line. A single clock drives the block, and the `ph2_i` input marks which clock cycles stand for the second phase of a dot. Counters advance and memory accesses start on first-phase edges. Video-level outputs (blank, active) change on second-phase edges, which puts them half a dot behind the counter.

Each dot 1 to 340 belongs to a two-dot memory access that starts on an odd dot. The line fetches tiles 3 to 34 of the current line, then eight sprite slots, then tiles 1 and 2 of the next line, then two throw-away nametable reads. Dot 0 issues an unused access.

Top module: `vid_fetch_seq`

## Requirements
- R1: While reset is held, the position reads line 0, dot 0. The write-enable, blank and active flags are 0.
- R2: The dot counter advances by one only on first-phase edges and holds on second-phase edges. After dot 340 it returns to 0 and the line advances by one. After line 261 the line returns to 0.
- R3: The write-enable flag is 0 from reset until the line counter first reaches 261. It becomes 1 on the same edge that makes the line 261, and it stays 1 afterwards.
- R4: On dot 0, the request is 1 and the type is the junk code 6.
- R5: On dots 1–256 and 321–336 the type follows 8-dot groups measured from dot 1. The order is nametable (code 1), attribute (2), pattern low (3) and pattern high (4), each held for 2 dots. The request is 1 on odd dots and 0 on even dots.
- R6: On dots 257–320 the type is sprite (code 5), and the request is 1 on odd dots only.
- R7: On dots 337–340 the type is nametable (code 1), and the request is 1 only on dots 337 and 339.
- R8: The horizontal-copy strobe is 1 exactly on dot 257 of lines 0–239 and of line 261. It is 0 on lines 240–260.
- R9: The vertical-copy strobe is 1 on line 261 for every dot from 280 through 304, and is 0 at all other times.
- R10: Horizontal blank rises on the second-phase edge of dot 280 and falls on the second-phase edge of dot 305, on every line.
- R11: On lines 0–239, the active flag rises on the second-phase edge of dot 4 and falls on the second-phase edge of dot 260. It stays 0 on lines 240–261.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, two cycles per dot |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ph2_i | input | 1 | 1 marks a second-phase clock cycle |
| dot_o | output | 9 | Dot position within the line |
| line_o | output | 9 | Scanline number |
| mem_req_o | output | 1 | Start of a memory access on this dot |
| fetch_kind_o | output | 3 | Access type: 1 nametable, 2 attribute, 3 pattern low, 4 pattern high, 5 sprite, 6 junk |
| copy_h_o | output | 1 | Copy horizontal scroll bits from T into V |
| copy_v_o | output | 1 | Copy vertical scroll bits from T into V |
| hblank_o | output | 1 | Horizontal blank |
| active_o | output | 1 | Active picture region |
| reg_wr_en_o | output | 1 | Control-register writes permitted |

## Verification
The schedule is tried against a table of dots on one visible line. The table covers every group boundary: dot 0, the first and last background groups, both edges of the sprite range, the next-line tiles and the trailing reads. A wrong group offset, a type swapped within a group, or a request on the wrong half of a pair each shows up as a mismatch.

Directed probes then take both halves of the dots where blank and active change, which separates a half-dot error from a whole-dot one. Further probes compare visible, post-render and pre-render lines, which shows whether the copy strobes and the active flag follow the line. The run also spans the first arrival at line 261 and the frame wrap, which covers the write-enable flag and counter rollover.

// File: rtl/vfs_pkg.sv
`timescale 1ns/1ps
package vfs_pkg;
  typedef enum logic [2:0] {
    FK_IDLE   = 3'd0,
    FK_NAME   = 3'd1,
    FK_ATTR   = 3'd2,
    FK_PATLO  = 3'd3,
    FK_PATHI  = 3'd4,
    FK_SPRITE = 3'd5,
    FK_JUNK   = 3'd6
  } fetch_kind_e;

  // fixed per-line timetable
  localparam int BG_LAST      = 256;
  localparam int SPR_FIRST    = 257;
  localparam int SPR_LAST     = 320;
  localparam int NEXT_FIRST   = 321;
  localparam int NEXT_LAST    = 336;
  localparam int HCOPY_DOT    = 257;
  localparam int VCOPY_FIRST  = 280;
  localparam int VCOPY_LAST   = 304;
  localparam int HBLANK_ON    = 280;
  localparam int HBLANK_OFF   = 305;
  localparam int ACTIVE_ON    = 4;
  localparam int ACTIVE_OFF   = 260;
endpackage

// File: rtl/vfs_counters.sv
`timescale 1ns/1ps
module vfs_counters #(
  parameter int DOTS     = 341,
  parameter int LINES    = 262,
  parameter int PRE_LINE = 261,
  parameter int DW       = 9,
  parameter int LW       = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv_i,
  output logic [DW-1:0] dot_o,
  output logic [LW-1:0] line_o,
  output logic          wr_en_o
);
  localparam logic [DW-1:0] DOT_LAST  = DW'(DOTS - 1);
  localparam logic [LW-1:0] LINE_LAST = LW'(LINES - 1);
  localparam logic [LW-1:0] LINE_PRE  = LW'(PRE_LINE);

  logic [DW-1:0] dot_q, dot_n;
  logic [LW-1:0] line_q, line_n;
  logic          wr_q, wr_n;

  always_comb begin
    dot_n  = dot_q;
    line_n = line_q;
    if (dot_q == DOT_LAST) begin
      dot_n  = '0;
      line_n = (line_q == LINE_LAST) ? '0 : line_q + 1'b1;
    end else begin
      dot_n = dot_q + 1'b1;
    end
    wr_n = wr_q | (line_n == LINE_PRE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dot_q  <= '0;
      line_q <= '0;
      wr_q   <= 1'b0;
    end else if (adv_i) begin
      dot_q  <= dot_n;
      line_q <= line_n;
      wr_q   <= wr_n;
    end
  end

  assign dot_o   = dot_q;
  assign line_o  = line_q;
  assign wr_en_o = wr_q;

  assert_dot_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && dot_q != DOT_LAST) |=> (dot_q == $past(dot_q) + 1'b1) && $stable(line_q));
  assert_dot_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && dot_q == DOT_LAST) |=> (dot_q == '0) && (line_q != $past(line_q)));
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !adv_i |=> $stable(dot_q) && $stable(line_q));
  assert_wr_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_q |=> wr_q);
  assert_wr_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_q) |-> line_q == LINE_PRE);
endmodule

// File: rtl/vfs_decode.sv
`timescale 1ns/1ps
module vfs_decode
  import vfs_pkg::*;
#(
  parameter int VIS_LINES = 240,
  parameter int PRE_LINE  = 261,
  parameter int DW        = 9,
  parameter int LW        = 9
) (
  input  logic [DW-1:0] dot_i,
  input  logic [LW-1:0] line_i,
  output logic          req_o,
  output fetch_kind_e   kind_o,
  output logic          copy_h_o,
  output logic          copy_v_o
);
  logic [DW-1:0] dm1;
  logic          in_bg, in_spr, render_line;

  always_comb begin
    dm1    = dot_i - 1'b1;
    in_bg  = ((dot_i != '0) && (dot_i <= DW'(BG_LAST))) ||
             ((dot_i >= DW'(NEXT_FIRST)) && (dot_i <= DW'(NEXT_LAST)));
    in_spr = (dot_i >= DW'(SPR_FIRST)) && (dot_i <= DW'(SPR_LAST));

    if (dot_i == '0)      kind_o = FK_JUNK;
    else if (in_spr)      kind_o = FK_SPRITE;
    else if (in_bg) begin
      unique case (dm1[2:1])
        2'd0:    kind_o = FK_NAME;
        2'd1:    kind_o = FK_ATTR;
        2'd2:    kind_o = FK_PATLO;
        default: kind_o = FK_PATHI;
      endcase
    end else              kind_o = FK_NAME;

    req_o = (dot_i == '0) | dot_i[0];

    render_line = (line_i < LW'(VIS_LINES)) || (line_i == LW'(PRE_LINE));
    copy_h_o    = render_line && (dot_i == DW'(HCOPY_DOT));
    copy_v_o    = (line_i == LW'(PRE_LINE)) &&
                  (dot_i >= DW'(VCOPY_FIRST)) && (dot_i <= DW'(VCOPY_LAST));
  end
endmodule

// File: rtl/vfs_video.sv
`timescale 1ns/1ps
module vfs_video
  import vfs_pkg::*;
#(
  parameter int VIS_LINES = 240,
  parameter int DW        = 9,
  parameter int LW        = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ph2_en_i,
  input  logic [DW-1:0] dot_i,
  input  logic [LW-1:0] line_i,
  output logic          hblank_o,
  output logic          active_o
);
  logic hb_q, hb_n, act_q, act_n;

  always_comb begin
    hb_n  = (dot_i >= DW'(HBLANK_ON)) && (dot_i < DW'(HBLANK_OFF));
    act_n = (line_i < LW'(VIS_LINES)) &&
            (dot_i >= DW'(ACTIVE_ON)) && (dot_i < DW'(ACTIVE_OFF));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hb_q  <= 1'b0;
      act_q <= 1'b0;
    end else if (ph2_en_i) begin
      hb_q  <= hb_n;
      act_q <= act_n;
    end
  end

  assign hblank_o = hb_q;
  assign active_o = act_q;

  assert_hblank_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hb_q) |-> (dot_i == DW'(HBLANK_ON)) && $past(ph2_en_i));
  assert_hblank_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hb_q) |-> (dot_i == DW'(HBLANK_OFF)) && $past(ph2_en_i));
  assert_active_rise_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(act_q) |-> (dot_i == DW'(ACTIVE_ON)) && (line_i < LW'(VIS_LINES)));
  assert_active_fall_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(act_q) |-> dot_i == DW'(ACTIVE_OFF));
endmodule

// File: rtl/vid_fetch_seq.sv
`timescale 1ns/1ps
module vid_fetch_seq
  import vfs_pkg::*;
#(
  parameter int DOTS        = 341,
  parameter int LINES       = 262,
  parameter int VIS_LINES   = 240,
  parameter int SYNC_STAGES = 2,
  localparam int DW         = $clog2(DOTS),
  localparam int LW         = $clog2(LINES),
  localparam int PRE_LINE   = LINES - 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ph2_i,
  output logic [DW-1:0] dot_o,
  output logic [LW-1:0] line_o,
  output logic          mem_req_o,
  output logic [2:0]    fetch_kind_o,
  output logic          copy_h_o,
  output logic          copy_v_o,
  output logic          hblank_o,
  output logic          active_o,
  output logic          reg_wr_en_o
);
  // reset: asserted at once, released through a synchronizer
  logic rst_s_n;
  generate
    if (SYNC_STAGES == 0) begin : g_nosync
      assign rst_s_n = rst_n;
    end else begin : g_sync
      logic [SYNC_STAGES-1:0] sync_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2+1-1:0], 1'b1} >> 0;
      end
      assign rst_s_n = sync_q[SYNC_STAGES-1];
    end
  endgenerate

  logic adv, ph2_en;
  assign adv    = ~ph2_i;
  assign ph2_en =  ph2_i;

  logic [DW-1:0] dot;
  logic [LW-1:0] line;
  logic          wr_en;

  vfs_counters #(.DOTS(DOTS), .LINES(LINES), .PRE_LINE(PRE_LINE), .DW(DW), .LW(LW)) u_cnt (
    .clk(clk), .rst_n(rst_s_n), .adv_i(adv),
    .dot_o(dot), .line_o(line), .wr_en_o(wr_en)
  );

  logic        req, ch, cv;
  fetch_kind_e kind;

  vfs_decode #(.VIS_LINES(VIS_LINES), .PRE_LINE(PRE_LINE), .DW(DW), .LW(LW)) u_dec (
    .dot_i(dot), .line_i(line),
    .req_o(req), .kind_o(kind), .copy_h_o(ch), .copy_v_o(cv)
  );

  vfs_video #(.VIS_LINES(VIS_LINES), .DW(DW), .LW(LW)) u_vid (
    .clk(clk), .rst_n(rst_s_n), .ph2_en_i(ph2_en),
    .dot_i(dot), .line_i(line),
    .hblank_o(hblank_o), .active_o(active_o)
  );

  assign dot_o        = dot;
  assign line_o       = line;
  assign mem_req_o    = req;
  assign fetch_kind_o = kind;
  assign copy_h_o     = ch;
  assign copy_v_o     = cv;
  assign reg_wr_en_o  = wr_en;

  assert_junk_dot0_R4: assert property (@(posedge clk) disable iff (!rst_s_n)
    (dot == '0) |-> req && (kind == FK_JUNK));
  assert_req_pair_R5: assert property (@(posedge clk) disable iff (!rst_s_n)
    (req && dot != '0 && adv) |=> !req);
  assert_kind_pair_R5: assert property (@(posedge clk) disable iff (!rst_s_n)
    (adv && dot[0]) |=> kind == $past(kind));
  assert_sprite_slot_R6: assert property (@(posedge clk) disable iff (!rst_s_n)
    (kind == FK_SPRITE) |-> (dot >= DW'(SPR_FIRST)) && (dot <= DW'(SPR_LAST)));
  assert_copy_h_R8: assert property (@(posedge clk) disable iff (!rst_s_n)
    ch |-> (kind == FK_SPRITE) && req && !((line >= LW'(VIS_LINES)) && (line < LW'(PRE_LINE))));
  assert_copy_v_run_R9: assert property (@(posedge clk) disable iff (!rst_s_n)
    (cv && adv && dot != DW'(VCOPY_LAST)) |=> cv);
  assert_copy_v_line_R9: assert property (@(posedge clk) disable iff (!rst_s_n)
    cv |-> wr_en && hblank_o | (dot == DW'(VCOPY_FIRST)));
endmodule

// File: tb/tb_vid_fetch_seq.sv
`timescale 1ns/1ps
module tb_vid_fetch_seq;
  logic       clk, rst_n, ph2;
  logic [8:0] dot, line;
  logic       req, ch, cv, hb, act, wr;
  logic [2:0] kind;

  vid_fetch_seq dut (
    .clk(clk), .rst_n(rst_n), .ph2_i(ph2),
    .dot_o(dot), .line_o(line), .mem_req_o(req), .fetch_kind_o(kind),
    .copy_h_o(ch), .copy_v_o(cv), .hblank_o(hb), .active_o(act), .reg_wr_en_o(wr)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  initial begin
    ph2 = 1'b0;
    forever begin
      @(negedge clk);
      ph2 = rst_n ? ~ph2 : 1'b0;
    end
  end

  int checks = 0, fails = 0, cycles = 0;
  bit done = 0;
  logic was_ph2;

  task automatic chk(input string r, input string what, input int a, input int e);
    checks++;
    if (a != e) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d (line %0d dot %0d)", r, what, a, e, line, dot);
    end
  endtask

  task automatic half();
    @(posedge clk);
    was_ph2 = ph2;
    #5;
  endtask

  // stop in the requested half of the given dot
  task automatic wait_at(input int l, input int d, input bit second);
    do half(); while (!(line == l && dot == d && was_ph2 == second));
  endtask

  typedef struct packed {
    logic [8:0] d;
    logic [2:0] k;
    logic       rq;
    logic       hc;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VEC [NV] = '{
    '{9'd0,   3'd6, 1'b1, 1'b0},
    '{9'd1,   3'd1, 1'b1, 1'b0},
    '{9'd2,   3'd1, 1'b0, 1'b0},
    '{9'd3,   3'd2, 1'b1, 1'b0},
    '{9'd5,   3'd3, 1'b1, 1'b0},
    '{9'd7,   3'd4, 1'b1, 1'b0},
    '{9'd8,   3'd4, 1'b0, 1'b0},
    '{9'd9,   3'd1, 1'b1, 1'b0},
    '{9'd255, 3'd4, 1'b1, 1'b0},
    '{9'd256, 3'd4, 1'b0, 1'b0},
    '{9'd257, 3'd5, 1'b1, 1'b1},
    '{9'd258, 3'd5, 1'b0, 1'b0},
    '{9'd320, 3'd5, 1'b0, 1'b0},
    '{9'd321, 3'd1, 1'b1, 1'b0},
    '{9'd323, 3'd2, 1'b1, 1'b0},
    '{9'd327, 3'd4, 1'b1, 1'b0},
    '{9'd329, 3'd1, 1'b1, 1'b0},
    '{9'd336, 3'd4, 1'b0, 1'b0},
    '{9'd337, 3'd1, 1'b1, 1'b0},
    '{9'd338, 3'd1, 1'b0, 1'b0},
    '{9'd339, 3'd1, 1'b1, 1'b0},
    '{9'd340, 3'd1, 1'b0, 1'b0}
  };

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 195000) begin
        checks++; fails++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        finish_run();
      end
    end
  end

  initial begin
    rst_n = 1'b0;
    repeat (4) @(posedge clk);
    #5;
    // R1 reset state
    chk("R1", "line", line, 0);
    chk("R1", "dot", dot, 0);
    chk("R1", "wr_en", wr, 0);
    chk("R1", "hblank", hb, 0);
    chk("R1", "active", act, 0);
    chk("R4", "kind dot0", kind, 6);
    chk("R4", "req dot0", req, 1);
    @(posedge clk); #3;
    rst_n = 1'b1;

    // R5 R6 R7 R8: schedule table on line 1
    for (int i = 0; i < NV; i++) begin
      wait_at(1, VEC[i].d, 1'b0);
      chk("R5/R6/R7 R4", "kind", kind, VEC[i].k);
      chk("R5/R6/R7 R4", "req", req, VEC[i].rq);
      chk("R8", "copy_h", ch, VEC[i].hc);
      chk("R9", "copy_v", cv, 0);
    end

    // R2: second half holds the dot, wrap 340 -> 0 bumps the line
    half();
    chk("R2", "dot held on phase 2", dot, 340);
    half();
    chk("R2", "dot wrap", dot, 0);
    chk("R2", "line step", line, 2);

    // R11 and R10 on line 2, both halves
    wait_at(2, 4, 1'b0);   chk("R11", "active dot4 first", act, 0);
    half();                chk("R11", "active dot4 second", act, 1);
    wait_at(2, 260, 1'b0); chk("R11", "active dot260 first", act, 1);
    half();                chk("R11", "active dot260 second", act, 0);
    wait_at(2, 280, 1'b0); chk("R10", "hblank dot280 first", hb, 0);
    half();                chk("R10", "hblank dot280 second", hb, 1);
    wait_at(2, 305, 1'b0); chk("R10", "hblank dot305 first", hb, 1);
    half();                chk("R10", "hblank dot305 second", hb, 0);

    // R8 last visible line vs post-render
    wait_at(239, 257, 1'b0); chk("R8", "copy_h line239", ch, 1);
    wait_at(240, 100, 1'b0); chk("R11", "active line240", act, 0);
    wait_at(240, 257, 1'b0); chk("R8", "copy_h line240", ch, 0);
    wait_at(240, 290, 1'b0); chk("R9", "copy_v line240", cv, 0);
                             chk("R10", "hblank line240", hb, 1);

    // R3 write enable
    wait_at(260, 340, 1'b1); chk("R3", "wr_en before 261", wr, 0);
    wait_at(261, 0, 1'b0);   chk("R3", "wr_en at 261", wr, 1);

    // R8 R9 pre-render line
    wait_at(261, 257, 1'b0); chk("R8", "copy_h pre-render", ch, 1);
    wait_at(261, 279, 1'b0); chk("R9", "copy_v dot279", cv, 0);
    wait_at(261, 280, 1'b0); chk("R9", "copy_v dot280", cv, 1);
    wait_at(261, 292, 1'b0); chk("R9", "copy_v dot292", cv, 1);
    wait_at(261, 304, 1'b0); chk("R9", "copy_v dot304", cv, 1);
    wait_at(261, 305, 1'b0); chk("R9", "copy_v dot305", cv, 0);
    wait_at(261, 100, 1'b1); ; // never reached again; guard avoided below
  end

  // frame wrap checks run from a second thread once line 261 dot 306 is seen
  initial begin
    wait (line == 261 && dot == 306);
    wait (line == 0 && dot == 0);
    #5;
    chk("R2", "frame wrap line", line, 0);
    chk("R4", "kind after wrap", kind, 6);
    chk("R3", "wr_en sticky", wr, 1);
    chk("R11", "active pre-render end", act, 0);
    finish_run();
  end
endmodule